// File: doc/BRIEF.md
# Commit-Gated Device Access Filter

This block sits between a load/store issue port and an external bus. Each incoming access carries an address, write data, a read/write flag and the reorder-buffer tag of the instruction that issued it. The address is compared against programmable address windows. Accesses outside every window are ordinary memory. They go to the bus in the same cycle they are offered, even while the instruction is still speculative.

Accesses that hit a window are device accesses. Such an access can have side effects, so it is parked in a four-entry holding buffer. It reaches the bus only when the commit head reports that the owning instruction is the oldest one in the machine. A squash that covers the instruction discards the parked access before it reaches the bus. A squash also swallows a matching access that is being offered in the same cycle. The bus is a plain valid/ready channel. A released device access has priority over pass-through traffic.

Instruction age is measured relative to the commit head tag, with wraparound: age = (tag - head_tag) mod 2^TAG_W. The flush tag names the oldest squashed instruction. Any access whose age is at least the flush tag's age is wrong-path.

Top module: `spec_dev_gate`

## Requirements
- R1: An address A is a device access when, for some window w, win_base[w] <= A <= win_limit[w] (both ends inclusive). Every other address is normal. Window w occupies bits [w*ADDR_W +: ADDR_W] of the flat base and limit ports. A window whose base is greater than its limit matches nothing.
- R2: Suppose a valid normal request is not squashed and no device access is being presented. Then bus_valid is 1 in the same cycle, with bus_dev = 0 and bus_addr, bus_wdata and bus_write equal to the request. In that case req_ready equals bus_ready.
- R3: A device request is never presented on the bus in the cycle it is accepted. At the earliest it appears one cycle later.
- R4: A parked device access is presented on the bus only in cycles where cmt_head_valid = 1 and cmt_head_tag equals its tag. It is then shown with bus_valid = 1 and bus_dev = 1 and its stored address, data and write flag.
- R5: While a device access is presented, a normal request that is not squashed sees req_ready = 0 and is not shown on the bus.
- R6: When flush_valid = 1, the following are discarded in that same cycle: every parked entry, and any incoming request, whose age is at least the age of flush_tag. A discarded entry never reaches the bus. A squashed normal request is absorbed (req_ready = 1) without bus_valid.
- R7: A presented device access leaves the buffer only on bus_valid and bus_ready. Otherwise it stays and is presented again with unchanged fields while its tag remains at the commit head.
- R8: For a device request, req_ready is 1 exactly when fewer than four entries were parked at the start of the cycle.
- R9: After reset the buffer is empty and no device access is presented.
- R10: At most one device access is on the bus in any cycle. Parked accesses leave in commit order, so they leave in tag order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access offered by the issue port |
| req_ready | output | 1 | Access taken this cycle |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Store data |
| req_write | input | 1 | 1 = store, 0 = load |
| req_tag | input | TAG_W | Reorder-buffer tag of the access |
| cmt_head_valid | input | 1 | Commit head tag is meaningful |
| cmt_head_tag | input | TAG_W | Tag of the oldest uncommitted instruction |
| flush_valid | input | 1 | Squash request |
| flush_tag | input | TAG_W | Oldest squashed tag |
| win_base | input | NWIN*ADDR_W | Device window lower bounds |
| win_limit | input | NWIN*ADDR_W | Device window upper bounds (inclusive) |
| bus_valid | output | 1 | Bus request valid |
| bus_ready | input | 1 | Bus accepts request |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus store data |
| bus_write | output | 1 | Bus store flag |
| bus_dev | output | 1 | 1 = released device access, 0 = pass-through |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and data, 4-bit tags, a four-entry buffer and two windows. The narrow tag makes the wraparound of the age comparison reachable within a few dozen requests. Flushes issued at random offsets from the commit head therefore split the buffer at every possible age boundary. A depth of four lets the bench fill the buffer in a handful of cycles, so it can test the full-buffer refusal and the retire-while-full case. Two windows let it probe both inclusive edges and the addresses just outside each window.

// File: rtl/spec_gate_pkg.sv
`timescale 1ns/1ps
package spec_gate_pkg;
  // Which source currently drives the external bus.
  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_NORM = 2'd1,
    SRC_DEV  = 2'd2
  } bus_src_e;
endpackage

// File: rtl/spec_gate_region.sv
`timescale 1ns/1ps
// Address classifier: device when inside any inclusive window (R1).
module spec_gate_region #(
  parameter int ADDR_W = 32,
  parameter int NWIN   = 2
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic [NWIN*ADDR_W-1:0] win_base,
  input  logic [NWIN*ADDR_W-1:0] win_limit,
  output logic                   is_dev
);
  logic [NWIN-1:0] hit;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic [ADDR_W-1:0] lo, hi;
    assign lo     = win_base[w*ADDR_W +: ADDR_W];
    assign hi     = win_limit[w*ADDR_W +: ADDR_W];
    assign hit[w] = (addr >= lo) && (addr <= hi);
  end

  assign is_dev = |hit;
endmodule

// File: rtl/spec_gate_pend.sv
`timescale 1ns/1ps
// Holding buffer for device accesses awaiting commit.
module spec_gate_pend #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_q_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_wdata,
  input  logic              push_write,
  input  logic [TAG_W-1:0]  push_tag,
  input  logic              head_valid,
  input  logic [TAG_W-1:0]  head_tag,
  input  logic              flush_valid,
  input  logic [TAG_W-1:0]  flush_tag,
  input  logic              pop,
  output logic              full,
  output logic              rel_valid,
  output logic [ADDR_W-1:0] rel_addr,
  output logic [DATA_W-1:0] rel_wdata,
  output logic              rel_write,
  output logic [CNT_W-1:0]  cnt
);
  logic [DEPTH-1:0]  vld_q, vld_n, kill, match, sel_oh, ld;
  logic [ADDR_W-1:0] addr_q  [DEPTH];
  logic [DATA_W-1:0] wdata_q [DEPTH];
  logic              write_q [DEPTH];
  logic [TAG_W-1:0]  tag_q   [DEPTH];
  logic [TAG_W-1:0]  flush_age;

  assign flush_age = flush_tag - head_tag;

  // Per-entry squash (R6) and commit match (R4).
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [TAG_W-1:0] ent_age;
    assign ent_age  = tag_q[i] - head_tag;
    assign kill[i]  = vld_q[i] && flush_valid && (ent_age >= flush_age);
    assign match[i] = vld_q[i] && head_valid && (tag_q[i] == head_tag) && !kill[i];
  end

  // Single release select, lowest index wins (R10).
  always_comb begin
    sel_oh = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i] && (sel_oh == '0)) sel_oh[i] = 1'b1;
    end
  end

  always_comb begin
    rel_addr  = '0;
    rel_wdata = '0;
    rel_write = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sel_oh[i]) begin
        rel_addr  = rel_addr  | addr_q[i];
        rel_wdata = rel_wdata | wdata_q[i];
        rel_write = rel_write | write_q[i];
      end
    end
  end

  assign rel_valid = |sel_oh;
  assign full      = &vld_q;

  // Allocation into lowest free slot.
  always_comb begin
    ld = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (push && !vld_q[i] && (ld == '0)) ld[i] = 1'b1;
    end
  end

  // Next state of occupancy (R7: leave only on handshake).
  always_comb begin
    vld_n = (vld_q & ~kill & ~(sel_oh & {DEPTH{pop}})) | ld;
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < DEPTH; i++) cnt = cnt + CNT_W'(vld_q[i]);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) vld_q <= '0;
    else          vld_q <= vld_n;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_pay
    always_ff @(posedge clk) begin
      if (ld[i]) begin
        addr_q[i]  <= push_addr;
        wdata_q[i] <= push_wdata;
        write_q[i] <= push_write;
        tag_q[i]   <= push_tag;
      end
    end
  end
endmodule

// File: rtl/spec_dev_gate.sv
`timescale 1ns/1ps
module spec_dev_gate
  import spec_gate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  parameter int DEPTH  = 4,
  parameter int NWIN   = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic                   req_write,
  input  logic [TAG_W-1:0]       req_tag,
  input  logic                   cmt_head_valid,
  input  logic [TAG_W-1:0]       cmt_head_tag,
  input  logic                   flush_valid,
  input  logic [TAG_W-1:0]       flush_tag,
  input  logic [NWIN*ADDR_W-1:0] win_base,
  input  logic [NWIN*ADDR_W-1:0] win_limit,
  output logic                   bus_valid,
  input  logic                   bus_ready,
  output logic [ADDR_W-1:0]      bus_addr,
  output logic [DATA_W-1:0]      bus_wdata,
  output logic                   bus_write,
  output logic                   bus_dev
);
  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  logic              req_is_dev, kill_in, full, push, pop, rel_valid, rel_write;
  logic [ADDR_W-1:0] rel_addr;
  logic [DATA_W-1:0] rel_wdata;
  logic [CNT_W-1:0]  cnt;
  logic [TAG_W-1:0]  req_age, fl_age;
  bus_src_e          src;

  spec_gate_region #(.ADDR_W(ADDR_W), .NWIN(NWIN)) region_i (
    .addr(req_addr), .win_base(win_base), .win_limit(win_limit), .is_dev(req_is_dev)
  );

  // Squash of the incoming request (R6).
  assign req_age = req_tag - cmt_head_tag;
  assign fl_age  = flush_tag - cmt_head_tag;
  assign kill_in = flush_valid && (req_age >= fl_age);

  assign push = req_valid && req_is_dev && !full && !kill_in;

  spec_gate_pend #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .DEPTH(DEPTH)) pend_i (
    .clk(clk), .rst_q_n(rst_q_n),
    .push(push), .push_addr(req_addr), .push_wdata(req_wdata),
    .push_write(req_write), .push_tag(req_tag),
    .head_valid(cmt_head_valid), .head_tag(cmt_head_tag),
    .flush_valid(flush_valid), .flush_tag(flush_tag),
    .pop(pop), .full(full), .rel_valid(rel_valid),
    .rel_addr(rel_addr), .rel_wdata(rel_wdata), .rel_write(rel_write), .cnt(cnt)
  );

  // Bus source: released device access first (R5), then pass-through (R2).
  always_comb begin
    if (rel_valid)                               src = SRC_DEV;
    else if (req_valid && !req_is_dev && !kill_in) src = SRC_NORM;
    else                                         src = SRC_IDLE;
  end

  always_comb begin
    bus_valid = (src != SRC_IDLE);
    bus_dev   = (src == SRC_DEV);
    if (src == SRC_DEV) begin
      bus_addr  = rel_addr;
      bus_wdata = rel_wdata;
      bus_write = rel_write;
    end else begin
      bus_addr  = req_addr;
      bus_wdata = req_wdata;
      bus_write = req_write;
    end
  end

  assign pop = (src == SRC_DEV) && bus_ready;

  // Ready: device by buffer space (R8); squashed normal absorbed (R6).
  always_comb begin
    if (req_is_dev)     req_ready = !full;
    else if (kill_in)   req_ready = 1'b1;
    else if (rel_valid) req_ready = 1'b0;
    else                req_ready = bus_ready;
  end
endmodule

// File: rtl/spec_dev_gate_chk.sv
`timescale 1ns/1ps
module spec_dev_gate_chk #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 4,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_is_dev,
  input logic              kill_in,
  input logic              full,
  input logic [CNT_W-1:0]  cnt,
  input logic              cmt_head_valid,
  input logic [TAG_W-1:0]  cmt_head_tag,
  input logic              flush_valid,
  input logic [TAG_W-1:0]  flush_tag,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_dev
);
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    cnt <= CNT_W'(DEPTH));

  p_full_blocks_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    full |-> !(req_is_dev && req_ready));

  p_pass_through_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && !req_is_dev && !kill_in && !(bus_valid && bus_dev))
      |-> (bus_valid && bus_addr == req_addr && req_ready == bus_ready));

  p_dev_priority_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_valid && bus_dev && !req_is_dev && !kill_in) |-> !req_ready);

  p_dev_needs_head_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_valid && bus_dev) |-> cmt_head_valid);

  p_flush_head_quiet_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (flush_valid && flush_tag == cmt_head_tag) |-> !bus_valid);

  p_flush_head_empties_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (flush_valid && flush_tag == cmt_head_tag) |=> (cnt == '0));

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_valid && bus_dev && !bus_ready && !flush_valid)
      |=> (!cmt_head_valid || !$stable(cmt_head_tag) || flush_valid
           || (bus_valid && bus_dev && $stable(bus_addr))));

  // R9: buffer empty while the internal reset is held.
  always @(posedge clk) begin
    if (!rst_q_n) begin
      p_reset_empty_r9: assert (cnt == '0);
    end
  end
endmodule

bind spec_dev_gate spec_dev_gate_chk #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_q_n(rst_q_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_is_dev(req_is_dev), .kill_in(kill_in), .full(full),
  .cnt(cnt), .cmt_head_valid(cmt_head_valid), .cmt_head_tag(cmt_head_tag),
  .flush_valid(flush_valid), .flush_tag(flush_tag), .bus_valid(bus_valid),
  .bus_ready(bus_ready), .bus_addr(bus_addr), .bus_dev(bus_dev)
);

// File: tb/spec_dev_gate_tb_top.sv
`timescale 1ns/1ps
module spec_dev_gate_tb_top;
  localparam int AW = 32, DW = 32, TW = 4, DEPTH = 4, NWIN = 2;
  localparam logic [AW-1:0] W0_LO = 32'h1000_0000, W0_HI = 32'h1000_FFFF;
  localparam logic [AW-1:0] W1_LO = 32'h2000_0000, W1_HI = 32'h2000_00FF;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic req_valid, req_ready, req_write, cmt_head_valid, flush_valid;
  logic [AW-1:0] req_addr, bus_addr;
  logic [DW-1:0] req_wdata, bus_wdata;
  logic [TW-1:0] req_tag, cmt_head_tag, flush_tag;
  logic bus_valid, bus_ready, bus_write, bus_dev;
  logic [NWIN*AW-1:0] win_base, win_limit;

  assign win_base  = {W1_LO, W0_LO};
  assign win_limit = {W1_HI, W0_HI};

  spec_dev_gate #(.ADDR_W(AW), .DATA_W(DW), .TAG_W(TW), .DEPTH(DEPTH), .NWIN(NWIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write), .req_tag(req_tag),
    .cmt_head_valid(cmt_head_valid), .cmt_head_tag(cmt_head_tag),
    .flush_valid(flush_valid), .flush_tag(flush_tag),
    .win_base(win_base), .win_limit(win_limit),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_write(bus_write), .bus_dev(bus_dev)
  );

  // Behavioural reference: a queue of parked device accesses.
  typedef struct {
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic          write;
    logic [TW-1:0] tag;
  } ent_t;
  ent_t q[$];

  int n_cmp = 0, n_bad = 0;

  function automatic logic in_win(input logic [AW-1:0] a);    // R1
    return ((a >= W0_LO) && (a <= W0_HI)) || ((a >= W1_LO) && (a <= W1_HI));
  endfunction

  function automatic logic squashed(input logic [TW-1:0] t);  // R6
    logic [TW-1:0] ta, fa;
    ta = t - cmt_head_tag;
    fa = flush_tag - cmt_head_tag;
    return flush_valid && (ta >= fa);
  endfunction

  task automatic chk(input string lbl, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", lbl, what, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 1'b0; req_addr = '0; req_wdata = '0; req_write = 1'b0; req_tag = '0;
    cmt_head_valid = 1'b0; cmt_head_tag = '0; flush_valid = 1'b0; flush_tag = '0;
    bus_ready = 1'b1;
  endtask

  task automatic req(input logic [AW-1:0] a, input logic [TW-1:0] t, input logic w);
    req_valid = 1'b1; req_addr = a; req_tag = t; req_write = w;
    req_wdata = {a[15:0], 12'h0, t};
  endtask

  // One cycle: compare at the falling edge, advance the model at the rising edge.
  task automatic step(input string lbl);
    int rel;
    logic dev, kin, ev, ed, er, ew, accept;
    logic [AW-1:0] ea;
    logic [DW-1:0] ewd;
    ent_t nq[$];
    ent_t ne;
    @(negedge clk);
    dev = in_win(req_addr);
    kin = squashed(req_tag);
    rel = -1;
    foreach (q[i]) if (cmt_head_valid && q[i].tag == cmt_head_tag && !squashed(q[i].tag)) rel = i;
    ev = 1'b0; ed = 1'b0; ea = '0; ewd = '0; ew = 1'b0;
    if (rel >= 0) begin
      ev = 1'b1; ed = 1'b1; ea = q[rel].addr; ewd = q[rel].wdata; ew = q[rel].write;
    end else if (req_valid && !dev && !kin) begin
      ev = 1'b1; ea = req_addr; ewd = req_wdata; ew = req_write;
    end
    if (dev)           er = (q.size() < DEPTH);
    else if (kin)      er = 1'b1;
    else if (rel >= 0) er = 1'b0;
    else               er = bus_ready;
    chk(lbl, "bus_valid", 64'(bus_valid), 64'(ev));
    chk(lbl, "req_ready", 64'(req_ready), 64'(er));
    if (ev) begin
      chk(lbl, "bus_dev", 64'(bus_dev), 64'(ed));
      chk(lbl, "bus_addr", 64'(bus_addr), 64'(ea));
      chk(lbl, "bus_wdata", 64'(bus_wdata), 64'(ewd));
      chk(lbl, "bus_write", 64'(bus_write), 64'(ew));
    end
    accept = req_valid && dev && (q.size() < DEPTH) && !kin;
    @(posedge clk);
    foreach (q[i]) if (!squashed(q[i].tag) && !(i == rel && bus_ready)) nq.push_back(q[i]);
    if (accept) begin
      ne.addr = req_addr; ne.wdata = req_wdata; ne.write = req_write; ne.tag = req_tag;
      nq.push_back(ne);
    end
    q = nq;
    #1;
  endtask

  function automatic logic tag_parked(input logic [TW-1:0] t);
    foreach (q[i]) if (q[i].tag == t) return 1'b1;
    return 1'b0;
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(5ns * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [TW-1:0] next_tag;
    idle();
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R9: empty after reset, device ready, nothing on bus.
    req(W0_LO, 4'd3, 1'b0); req_valid = 1'b0;
    step("R9 reset state");

    // R2: pass-through with and without bus ready.
    req(32'h0000_4000, 4'd1, 1'b1); step("R2 normal pass");
    bus_ready = 1'b0; step("R2 normal stalled"); bus_ready = 1'b1;
    idle();

    // R1 + R3: window edges; device accepted, not on bus the same cycle.
    req(W0_LO, 4'd3, 1'b0);      step("R1 R3 win0 base device");
    req(W0_HI, 4'd4, 1'b1);      step("R1 win0 limit device");
    req(W0_HI + 1, 4'd5, 1'b0);  step("R1 past win0 normal");
    req(W1_LO - 1, 4'd5, 1'b0);  step("R1 below win1 normal");
    req(W1_HI, 4'd6, 1'b1);      step("R1 win1 limit device");
    idle();
    cmt_head_valid = 1'b1; cmt_head_tag = 4'd1;
    step("R4 held while not at head");

    // R4 + R5 + R7: release at head, stall, normal blocked, then retire.
    cmt_head_tag = 4'd3; bus_ready = 1'b0;
    req(32'h0000_8000, 4'd7, 1'b0);
    step("R5 R7 device stalled, normal blocked");
    step("R7 device held");
    bus_ready = 1'b1; step("R4 R7 device retires");
    req_valid = 1'b0;
    cmt_head_tag = 4'd4; step("R10 next in tag order");
    cmt_head_tag = 4'd6; step("R10 third entry");
    step("R7 retired entry gone");

    // R8: fill the buffer, fifth device request refused.
    cmt_head_tag = 4'd8;
    req(W0_LO + 16, 4'd9, 1'b0);  step("R8 fill 1");
    req(W0_LO + 32, 4'd10, 1'b1); step("R8 fill 2");
    req(W1_LO + 4, 4'd11, 1'b0);  step("R8 fill 3");
    req(W1_LO + 8, 4'd12, 1'b1);  step("R8 fill 4");
    req(W0_LO + 48, 4'd13, 1'b0); step("R8 full refuses");

    // R6: squash from tag 11 drops 11 and 12, and a same-cycle normal request.
    req(32'h0000_0100, 4'd14, 1'b0);
    flush_valid = 1'b1; flush_tag = 4'd11;
    step("R6 flush partial + absorb");
    flush_valid = 1'b0; req_valid = 1'b0;
    cmt_head_tag = 4'd11; step("R6 squashed entry never on bus");
    cmt_head_tag = 4'd12; step("R6 squashed entry never on bus");
    cmt_head_tag = 4'd9;  step("R4 survivor released");
    cmt_head_tag = 4'd10; step("R4 survivor released");

    // R6 wrap: head 14, flush at 1 (age 3) keeps 15 and 0, drops 2.
    cmt_head_tag = 4'd14;
    req(W0_LO, 4'd15, 1'b0); step("R6 wrap fill");
    req(W0_LO + 4, 4'd0, 1'b1); step("R6 wrap fill");
    req(W0_LO + 8, 4'd2, 1'b0); step("R6 wrap fill");
    req_valid = 1'b0; flush_valid = 1'b1; flush_tag = 4'd1;
    step("R6 wrap flush");
    flush_valid = 1'b0;
    cmt_head_tag = 4'd2;  step("R6 wrapped squash absent");
    cmt_head_tag = 4'd15; step("R6 wrapped survivor");
    cmt_head_tag = 4'd0;  step("R6 wrapped survivor");

    // Random mix, all requirements, compared every cycle.
    idle();
    next_tag = 4'd1;
    for (int c = 0; c < 4000; c++) begin
      int sel;
      logic [AW-1:0] a;
      sel = $urandom_range(0, 5);
      case (sel)
        0: a = W0_LO + AW'($urandom_range(0, 3));
        1: a = W0_HI - AW'($urandom_range(0, 3));
        2: a = W1_LO + AW'($urandom_range(0, 255));
        3: a = W1_HI + AW'($urandom_range(0, 3));
        default: a = AW'($urandom);
      endcase
      req_valid = ($urandom_range(0, 1) == 1);
      if (in_win(a)) begin
        if (tag_parked(next_tag)) a = 32'h0000_0040;
        req(a, next_tag, $urandom_range(0, 1) == 1);
        if (in_win(a)) next_tag = next_tag + 1'b1;
      end else begin
        req(a, TW'($urandom), $urandom_range(0, 1) == 1);
      end
      req_valid = ($urandom_range(0, 1) == 1);
      cmt_head_valid = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 2) == 0 || q.size() == 0) cmt_head_tag = TW'($urandom);
      else cmt_head_tag = q[0].tag;
      flush_valid = ($urandom_range(0, 15) == 0);
      flush_tag = cmt_head_tag + TW'($urandom_range(0, 7));
      bus_ready = ($urandom_range(0, 2) != 0);
      step("R2 R4 R5 R6 R7 R8 R10 random");
    end

    summary();
    $finish;
  end
endmodule